// File: doc/BRIEF.md
# USB Bridge Synchronous FIFO Video Writer

This block moves a stream of 16-bit video words from on-chip logic into a USB 2.0 bridge device that is set up as a synchronous slave FIFO. Every register in the block runs on the interface clock that the bridge itself supplies. Words arrive over a valid/ready handshake, with a marker on the last word of each frame. The block drives the bridge's chip select, write strobe, packet-end strobe and endpoint address onto the write bus, and places the word on the data bus.

The bridge's full flag holds writes back. A new frame begins with one select cycle, in which the endpoint address is latched and chip select goes low. The block then streams words. When the last word of a frame leaves a packet only partly filled, the block sends a single packet-end pulse so the bridge commits the short packet. A frame that ends exactly on a packet boundary gets no pulse, because the bridge has already shipped that packet by itself.

Top module: `usb_fifo_writer`

## Requirements
- R1: While reset is asserted, and afterwards until a word is offered, cs_no, wr_no, pktend_no, oe_no and rd_no are all 1 and s_ready_o is 0.
- R2: oe_no and rd_no are 1 in every cycle, so the bridge never drives the data bus.
- R3: A frame starts when s_valid_i is seen in the idle state. For exactly one cycle, cs_no is 0 and wr_no is 1, and only after that cycle are words written. fifoadr_o carries the value of ep_addr_i sampled in the cycle in which the frame started.
- R4: A word is written (wr_no=0) in a cycle where the block is streaming, s_valid_i=1 and full_ni=1. s_ready_o is 1 in exactly those cycles, and fd_o carries s_data_i. Each word is written once, in order, and none is lost.
- R5: No word is written in any cycle where full_ni is 0 (full is active low).
- R6: wr_no is 0 only while cs_no is 0. fifoadr_o stays stable for as long as cs_no is 0, even if ep_addr_i changes during the frame.
- R7: A frame can end part-way through a packet, meaning the word count of the frame modulo PKT_WORDS is not zero. In that case pktend_no is 0 for exactly one cycle, the cycle right after the last word is written, with cs_no=0 and wr_no=1.
- R8: A frame whose length is a non-zero multiple of PKT_WORDS produces no packet-end pulse.
- R9: The position within a packet wraps every PKT_WORDS words, so a frame longer than one packet ends with a pulse exactly when its final packet is partial.
- R10: After each frame the block returns to idle with cs_no=1. It starts the next frame with a fresh packet count and a newly sampled endpoint address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock supplied by the bridge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_addr_i | input | 2 | Endpoint to use for the next frame |
| s_data_i | input | 16 | Upstream video word |
| s_valid_i | input | 1 | Upstream word valid |
| s_last_i | input | 1 | Marks the last word of a frame |
| s_ready_o | output | 1 | Word accepted this cycle |
| full_ni | input | 1 | Bridge FIFO full flag, active low |
| cs_no | output | 1 | Bridge chip select, active low |
| oe_no | output | 1 | Bridge output enable, held inactive |
| rd_no | output | 1 | Bridge read strobe, held inactive |
| wr_no | output | 1 | Bridge write strobe, active low |
| pktend_no | output | 1 | Packet commit strobe, active low |
| fifoadr_o | output | 2 | Bridge endpoint address |
| fd_o | output | 16 | Bridge data bus |

## Verification
The hardest case to reach is a frame whose last word is accepted while the full flag is toggling, and whose length has wrapped past a packet boundary. The packet-end decision then depends both on the wrapped count and on the exact cycle in which that last write lands. The stimulus uses a short packet size and runs frames of 5, 8, 16, 11, 1 and 20 words. The 20-word frame runs under a periodic full pattern, and a later frame starts under a long full hold. The endpoint input is flipped right after the first accepted word of each frame, so any late re-sampling of the address shows up in the scoreboard.

// File: rtl/usb_fifo_writer_pkg.sv
package usb_fifo_writer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SELECT = 2'd1,
    ST_WRITE  = 2'd2,
    ST_PKTEND = 2'd3
  } uw_state_e;
endpackage

// File: rtl/uw_pkt_counter.sv
module uw_pkt_counter #(
  parameter int PKT_WORDS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic last_i,
  output logic partial_o
);
  localparam int CW = (PKT_WORDS > 2) ? $clog2(PKT_WORDS) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(PKT_WORDS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (fire_i && last_i)       cnt_q <= '0;
    else if (fire_i)                 cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
  end

  // word being written does not close a packet
  assign partial_o = (cnt_q != CNT_TOP);

  assert_cnt_fresh_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fire_i && last_i) |-> (cnt_q == '0));
endmodule

// File: rtl/uw_ctrl_fsm.sv
module uw_ctrl_fsm
  import usb_fifo_writer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      fire_i,
  input  logic      last_i,
  input  logic      partial_i,
  output uw_state_e state_o
);
  uw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (valid_i) state_d = ST_SELECT;
      ST_SELECT: state_d = ST_WRITE;
      ST_WRITE:  if (fire_i && last_i) state_d = partial_i ? ST_PKTEND : ST_IDLE;
      ST_PKTEND: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_pktend_follows_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PKTEND) |-> $past(fire_i && last_i && partial_i));
  assert_select_then_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SELECT) |=> (state_q == ST_WRITE));
endmodule

// File: rtl/uw_bus_drive.sv
module uw_bus_drive
  import usb_fifo_writer_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  uw_state_e     state_i,
  input  logic [AW-1:0] ep_addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  input  logic          full_ni,
  output logic          fire_o,
  output logic          cs_no,
  output logic          oe_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic          pktend_no,
  output logic [AW-1:0] fifoadr_o,
  output logic [DW-1:0] fd_o
);
  logic [AW-1:0] adr_q;

  // endpoint is captured only when a frame opens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             adr_q <= '0;
    else if (state_i == ST_IDLE && valid_i)  adr_q <= ep_addr_i;
  end

  assign fire_o    = (state_i == ST_WRITE) && valid_i && full_ni;
  assign cs_no     = (state_i == ST_IDLE);
  assign wr_no     = !fire_o;
  assign pktend_no = (state_i != ST_PKTEND);
  assign oe_no     = 1'b1;
  assign rd_no     = 1'b1;
  assign fifoadr_o = adr_q;
  assign fd_o      = data_i;
endmodule

// File: rtl/usb_fifo_writer.sv
module usb_fifo_writer
  import usb_fifo_writer_pkg::*;
#(
  parameter int PKT_WORDS = 256,
  parameter int DW        = 16,
  parameter int AW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ep_addr_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_valid_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  input  logic          full_ni,
  output logic          cs_no,
  output logic          oe_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic          pktend_no,
  output logic [AW-1:0] fifoadr_o,
  output logic [DW-1:0] fd_o
);
  uw_state_e state;
  logic      fire;
  logic      partial;

  uw_ctrl_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (s_valid_i),
    .fire_i    (fire),
    .last_i    (s_last_i),
    .partial_i (partial),
    .state_o   (state)
  );

  uw_pkt_counter #(.PKT_WORDS(PKT_WORDS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .last_i    (s_last_i),
    .partial_o (partial)
  );

  uw_bus_drive #(.DW(DW), .AW(AW)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .ep_addr_i (ep_addr_i),
    .data_i    (s_data_i),
    .valid_i   (s_valid_i),
    .full_ni   (full_ni),
    .fire_o    (fire),
    .cs_no     (cs_no),
    .oe_no     (oe_no),
    .rd_no     (rd_no),
    .wr_no     (wr_no),
    .pktend_no (pktend_no),
    .fifoadr_o (fifoadr_o),
    .fd_o      (fd_o)
  );

  // ready mirrors the bus write so a full flag mid-burst drops nothing
  assign s_ready_o = fire;

  assert_no_write_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_ni |-> wr_no);
  assert_write_in_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> !cs_no);
  assert_adr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(fifoadr_o));
  assert_select_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> wr_no);
  assert_pktend_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pktend_no |=> pktend_no);
  assert_pktend_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pktend_no |=> cs_no);
  assert_read_side_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (oe_no && rd_no));
endmodule

// File: tb/usb_fifo_writer_tb_top.sv
module usb_fifo_writer_tb_top;
  localparam int PKT = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  ep_addr_i;
  logic [15:0] s_data_i;
  logic        s_valid_i;
  logic        s_last_i;
  logic        s_ready_o;
  logic        full_ni;
  logic        cs_no, oe_no, rd_no, wr_no, pktend_no;
  logic [1:0]  fifoadr_o;
  logic [15:0] fd_o;

  always #2.5 clk_i = ~clk_i;

  usb_fifo_writer #(.PKT_WORDS(PKT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ep_addr_i(ep_addr_i), .s_data_i(s_data_i),
    .s_valid_i(s_valid_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o), .full_ni(full_ni),
    .cs_no(cs_no), .oe_no(oe_no), .rd_no(rd_no), .wr_no(wr_no), .pktend_no(pktend_no),
    .fifoadr_o(fifoadr_o), .fd_o(fd_o)
  );

  int checks = 0, failures = 0;
  int r2_err = 0, r5_err = 0, r6_err = 0, r7_err = 0;
  int pk_seen = 0, exp_pk = 0, frame_no = 0;
  int full_mode = 0, hold = 0, cyc = 0;
  logic [18:0] exp_q[$];   // {ep, data, last}

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // full flag generator
  initial begin
    full_ni = 1'b1;
    forever begin
      @(negedge clk_i);
      cyc++;
      case (full_mode)
        1: full_ni = ((cyc % 5) >= 2);
        2: begin full_ni = (hold >= 12); hold++; end
        default: full_ni = 1'b1;
      endcase
    end
  end

  // monitor / scoreboard, samples just before each rising edge
  logic prev_cs = 1'b1, prev_pk = 1'b1, prev_last_wr = 1'b0;
  logic [1:0] prev_adr = '0;
  initial begin
    forever begin
      @(negedge clk_i); #1;
      if (rst_ni) begin
        if (oe_no !== 1'b1 || rd_no !== 1'b1) r2_err++;
        if (!full_ni && !wr_no) r5_err++;
        if (!wr_no && cs_no) r6_err++;
        if (!cs_no && !prev_cs && fifoadr_o != prev_adr) r6_err++;
        if (prev_cs && !cs_no)
          chk(wr_no === 1'b1, "R3", "write in select cycle wr_no", int'(wr_no), 1);
        if (!pktend_no) begin
          pk_seen++;
          if (!prev_last_wr || !wr_no || cs_no || !prev_pk) r7_err++;
        end
        if (!cs_no && !wr_no) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected write, data", int'(fd_o), -1);
            prev_last_wr = 1'b0;
          end else begin
            logic [18:0] it;
            it = exp_q.pop_front();
            chk(fd_o == it[16:1], "R4", "written data", int'(fd_o), int'(it[16:1]));
            chk(fifoadr_o == it[18:17], "R3", "endpoint address", int'(fifoadr_o), int'(it[18:17]));
            chk(s_ready_o === 1'b1, "R4", "ready with write", int'(s_ready_o), 1);
            prev_last_wr = it[0];
          end
        end else begin
          prev_last_wr = 1'b0;
        end
        prev_cs  = cs_no;
        prev_adr = fifoadr_o;
        prev_pk  = pktend_no;
      end
    end
  end

  task automatic send_frame(input logic [1:0] ep, input int n, input bit gaps, input string req);
    bit hs;
    ep_addr_i = ep;
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = {ep, 4'(frame_no), 10'(i)};
      exp_q.push_back({ep, d, (i == n - 1)});
      s_valid_i = 1'b1; s_data_i = d; s_last_i = (i == n - 1);
      do begin
        #1; hs = s_ready_o;
        @(negedge clk_i);
      end while (!hs);
      ep_addr_i = ~ep;   // must not reach the bus mid-frame
      if (gaps && i[0]) begin
        s_valid_i = 1'b0; s_last_i = 1'b0;
        repeat (2) @(negedge clk_i);
      end
    end
    s_valid_i = 1'b0; s_last_i = 1'b0;
    if (n % PKT != 0) exp_pk++;
    repeat (4) @(negedge clk_i);
    #1;
    chk(pk_seen == exp_pk, req, "packet-end pulses so far", pk_seen, exp_pk);
    chk(cs_no === 1'b1, "R10", "idle after frame cs_no", int'(cs_no), 1);
    @(negedge clk_i);
    frame_no++;
  endtask

  initial begin
    rst_ni = 1'b0; ep_addr_i = '0; s_data_i = '0; s_valid_i = 1'b0; s_last_i = 1'b0;
    repeat (3) @(negedge clk_i); #1;
    chk(cs_no === 1'b1 && wr_no === 1'b1 && pktend_no === 1'b1, "R1", "reset strobes", int'({cs_no, wr_no, pktend_no}), 7);
    chk(oe_no === 1'b1 && rd_no === 1'b1, "R1", "reset read strobes", int'({oe_no, rd_no}), 3);
    chk(s_ready_o === 1'b0, "R1", "reset ready", int'(s_ready_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(negedge clk_i); #1;
    chk(cs_no === 1'b1 && s_ready_o === 1'b0, "R1", "idle after reset", int'({cs_no, s_ready_o}), 2);
    @(negedge clk_i);

    send_frame(2'd1, 5,  1'b0, "R7");
    send_frame(2'd2, 8,  1'b0, "R8");
    send_frame(2'd3, 16, 1'b1, "R8");
    send_frame(2'd0, 11, 1'b0, "R9");
    send_frame(2'd2, 1,  1'b0, "R7");
    full_mode = 1;
    send_frame(2'd1, 20, 1'b1, "R9");
    hold = 0; full_mode = 2;
    send_frame(2'd3, 3,  1'b0, "R5");
    full_mode = 0;
    send_frame(2'd0, 24, 1'b0, "R8");

    chk(exp_q.size() == 0, "R4", "words left unwritten", exp_q.size(), 0);
    chk(r2_err == 0, "R2", "read-side strobe active cycles", r2_err, 0);
    chk(r5_err == 0, "R5", "writes while full", r5_err, 0);
    chk(r6_err == 0, "R6", "cs/address violations", r6_err, 0);
    chk(r7_err == 0, "R7", "misplaced packet-end pulses", r7_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule